// File: doc/BRIEF.md
# Multi-Cycle Flash Command Sequencer

This block puts a small word-wide array behind the bus-cycle command protocol of a parallel NOR flash. A host performs a write cycle by placing an address and a data byte on the bus and pulling an active-low write strobe low. The block samples the strobe on its own clock, and the high-to-low transition marks one bus cycle. A short sequence of such cycles is decoded into one of three operations: program one word, erase one sector, or erase a whole plane. The operation is then applied to a register array held inside the block.

Each sector has a protection bit supplied from outside. The array acts like flash cells. Programming can only clear bits. Erase sets every bit of the target to one. A sector whose protection bit is set is never changed. When a program or a sector erase aims at such a sector, the block raises a failure flag. A plane erase passes over protected sectors without raising the flag. After each accepted operation, the busy output stays high for a fixed, parameterised number of clocks.

The bus has no handshake and no back-pressure. The rule is simple: strobe edges that arrive while busy is high are dropped, and they do not advance the decoder. The read port is a plain combinational lookup and is always available.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset every word reads 0xFF, busy is 0 and the fail flag is 0.
- R2: Four bus cycles program one word: 0xAA at address 0x15, then 0x55 at 0x2A, then 0xA0 at 0x15, then the data byte at the target address. In the fourth cycle the stored word becomes the old word AND the new data.
- R3: Programming never turns a 0 bit into 1. Programming 0x3C and then 0xF0 into the same word leaves 0x30.
- R4: Six bus cycles erase one sector: 0xAA@0x15, 0x55@0x2A, 0x80@0x15, 0xAA@0x15, 0x55@0x2A, and then 0x30 at any address inside the sector. The sector index is address bits [5:2], so a sector holds four words. All four words then read 0xFF and fail becomes 0.
- R5: The same five prefix cycles followed by 0x20 erase one plane. The plane index is address bits [5:4], so a plane holds sectors 4p to 4p+3. Every unprotected sector of that plane reads 0xFF afterwards. Protected sectors and other planes keep their contents, and fail becomes 0.
- R6: A program or a sector erase whose sector has its protection bit set (sect_prot[addr[5:2]] = 1 on the final cycle) changes no word and sets fail to 1. Fail changes only when a command completes.
- R7: A bus cycle that does not match the address and byte expected at that step returns the decoder to idle, and that cycle is discarded. A later correct sequence is then accepted normally.
- R8: Busy is high for exactly BUSY_CYC (default 5) clocks, starting with the clock edge that accepts a command. Strobe edges seen while busy is high are ignored.
- R9: A bus cycle is counted only on a high-to-low transition of we_n. Holding we_n low for several clocks counts as one cycle.
- R10: rd_data shows the word at rd_addr combinationally. A word committed at a clock edge is visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we_n | input | 1 | Active-low write strobe; a falling transition marks a bus cycle |
| addr | input | 6 | Bus cycle address |
| wdata | input | 8 | Bus cycle data / command byte |
| sect_prot | input | 16 | Per-sector protection, 1 = locked |
| rd_addr | input | 6 | Read address |
| rd_data | output | 8 | Word at rd_addr |
| busy | output | 1 | High while a command is in progress |
| op_fail | output | 1 | Set when the last command hit a protected sector |

## Verification
Two events can meet on one clock edge, and both are provoked on purpose.

The first is a strobe falling edge that lands while the busy counter is draining. A second program sequence is issued straight after the first one. Its early cycles fall inside the busy window, and its later cycles arrive once the decoder has returned to idle and therefore mismatch. The reference model replays the same edge-by-edge rule and is compared on every clock. A directed check confirms that the second target word is still 0xFF.

The second is a program commit and a read of the same word. The read address is held on the target across the final bus cycle. The bench checks that rd_data shows the old value before the accepting edge and the new value immediately after it.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_KEY1, ST_KEY2, ST_PGM, ST_ER3, ST_ER4, ST_ER5
  } seq_st_t;

  typedef enum logic [1:0] {
    OP_PROG, OP_SERASE, OP_PERASE
  } op_kind_t;

  localparam logic [7:0] CMD_KEY1  = 8'hAA;
  localparam logic [7:0] CMD_KEY2  = 8'h55;
  localparam logic [7:0] CMD_PROG  = 8'hA0;
  localparam logic [7:0] CMD_ERASE = 8'h80;
  localparam logic [7:0] CMD_SECT  = 8'h30;
  localparam logic [7:0] CMD_PLANE = 8'h20;
endpackage

// File: rtl/fseq_strobe.sv
module fseq_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic we_n,
  output logic fall
);
  logic we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= 1'b1;
    else        we_q <= we_n;
  end

  assign fall = we_q & ~we_n;
endmodule

// File: rtl/fseq_decoder.sv
module fseq_decoder
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR1 = 'h15,
  parameter logic [ADDR_W-1:0] KEY_ADDR2 = 'h2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              op_valid,
  output op_kind_t          op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data
);
  seq_st_t st, st_nxt;
  logic take, key1, key2, at_a1;
  logic [7:0] cb;

  assign take  = fall & ~busy;
  assign cb    = wdata[7:0];
  assign at_a1 = (addr == KEY_ADDR1);
  assign key1  = at_a1 && (cb == CMD_KEY1);
  assign key2  = (addr == KEY_ADDR2) && (cb == CMD_KEY2);

  assign op_addr = addr;
  assign op_data = wdata;

  always_comb begin
    st_nxt   = st;
    op_valid = 1'b0;
    op_kind  = OP_PROG;
    if (take) begin
      st_nxt = ST_IDLE;
      case (st)
        ST_IDLE: if (key1) st_nxt = ST_KEY1;
        ST_KEY1: if (key2) st_nxt = ST_KEY2;
        ST_KEY2: begin
          if (at_a1 && cb == CMD_PROG)       st_nxt = ST_PGM;
          else if (at_a1 && cb == CMD_ERASE) st_nxt = ST_ER3;
        end
        ST_PGM: begin
          op_valid = 1'b1;
          op_kind  = OP_PROG;
        end
        ST_ER3: if (key1) st_nxt = ST_ER4;
        ST_ER4: if (key2) st_nxt = ST_ER5;
        ST_ER5: begin
          if (cb == CMD_SECT) begin
            op_valid = 1'b1;
            op_kind  = OP_SERASE;
          end else if (cb == CMD_PLANE) begin
            op_valid = 1'b1;
            op_kind  = OP_PERASE;
          end
        end
        default: st_nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nxt;
  end
endmodule

// File: rtl/fseq_busy.sv
module fseq_busy #(
  parameter int BUSY_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (start)       cnt <= CNT_W'(BUSY_CYC);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/fseq_array.sv
module fseq_array
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W         = 6,
  parameter int DATA_W         = 8,
  parameter int PLANES         = 4,
  parameter int SECT_PER_PLANE = 4,
  localparam int SECTORS       = PLANES * SECT_PER_PLANE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  op_kind_t           op_kind,
  input  logic [ADDR_W-1:0]  op_addr,
  input  logic [DATA_W-1:0]  op_data,
  input  logic [SECTORS-1:0] sect_prot,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               op_fail
);
  localparam int SEC_W  = $clog2(SECTORS);
  localparam int PL_W   = $clog2(PLANES);
  localparam int OFF_W  = ADDR_W - SEC_W;
  localparam int SWORDS = 1 << OFF_W;
  localparam int WORDS  = 1 << ADDR_W;

  logic [SEC_W-1:0] sec_idx;
  logic [PL_W-1:0]  pl_idx;
  logic [OFF_W-1:0] off;
  logic [SECTORS-1:0] wipe, pgm;
  logic [DATA_W-1:0] mem [WORDS];

  assign sec_idx = op_addr[ADDR_W-1 -: SEC_W];
  assign pl_idx  = op_addr[ADDR_W-1 -: PL_W];
  assign off     = op_addr[OFF_W-1:0];

  for (genvar s = 0; s < SECTORS; s++) begin : g_sect
    localparam int PL = s / SECT_PER_PLANE;
    logic hit_sec, hit_pl;
    assign hit_sec = (sec_idx == SEC_W'(s));
    assign hit_pl  = (pl_idx == PL_W'(PL));
    assign wipe[s] = op_valid && !sect_prot[s] &&
                     ((op_kind == OP_SERASE && hit_sec) ||
                      (op_kind == OP_PERASE && hit_pl));
    assign pgm[s]  = op_valid && !sect_prot[s] &&
                     (op_kind == OP_PROG) && hit_sec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else begin
      for (int i = 0; i < WORDS; i++) begin
        if (wipe[i / SWORDS])
          mem[i] <= '1;
        else if (pgm[i / SWORDS] && off == OFF_W'(i % SWORDS))
          mem[i] <= mem[i] & op_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        op_fail <= 1'b0;
    else if (op_valid) op_fail <= (op_kind != OP_PERASE) && sect_prot[sec_idx];
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W         = 6,
  parameter int DATA_W         = 8,
  parameter int PLANES         = 4,
  parameter int SECT_PER_PLANE = 4,
  parameter int BUSY_CYC       = 5,
  parameter logic [ADDR_W-1:0] KEY_ADDR1 = 'h15,
  parameter logic [ADDR_W-1:0] KEY_ADDR2 = 'h2A,
  localparam int SECTORS       = PLANES * SECT_PER_PLANE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [SECTORS-1:0] sect_prot,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               busy,
  output logic               op_fail
);
  logic              fall;
  logic              op_valid;
  op_kind_t          op_kind;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_data;

  fseq_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .we_n(we_n), .fall(fall)
  );

  fseq_decoder #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .KEY_ADDR1(KEY_ADDR1), .KEY_ADDR2(KEY_ADDR2)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .fall(fall), .busy(busy),
    .addr(addr), .wdata(wdata),
    .op_valid(op_valid), .op_kind(op_kind),
    .op_addr(op_addr), .op_data(op_data)
  );

  fseq_busy #(.BUSY_CYC(BUSY_CYC)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(op_valid), .busy(busy)
  );

  fseq_array #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PLANES(PLANES), .SECT_PER_PLANE(SECT_PER_PLANE)
  ) u_arr (
    .clk(clk), .rst_n(rst_n),
    .op_valid(op_valid), .op_kind(op_kind),
    .op_addr(op_addr), .op_data(op_data),
    .sect_prot(sect_prot), .rd_addr(rd_addr),
    .rd_data(rd_data), .op_fail(op_fail)
  );
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int SECTORS  = 16,
  parameter int BUSY_CYC = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               we_n,
  input logic               fall,
  input logic               busy,
  input logic               op_fail,
  input logic               op_valid,
  input op_kind_t           op_kind,
  input logic [ADDR_W-1:0]  op_addr,
  input logic [SECTORS-1:0] sect_prot
);
  localparam int SEC_W = $clog2(SECTORS);
  logic prot_hit;
  int   run_len;

  assign prot_hit = sect_prot[op_addr[ADDR_W-1 -: SEC_W]];

  // R8
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> busy);

  // R8
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !op_valid);

  // R6
  prot_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind != OP_PERASE && prot_hit) |=> op_fail);

  // R5
  plane_nofail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == OP_PERASE) |=> !op_fail);

  // R6
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(op_fail));

  // R9
  edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> (!we_n && $past(we_n)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= 0;
    else begin
      run_len <= busy ? run_len + 1 : 0;
      // R8
      busy_len_chk: assert (run_len <= BUSY_CYC);
    end
  end
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(
  .ADDR_W(ADDR_W), .SECTORS(SECTORS), .BUSY_CYC(BUSY_CYC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .we_n(we_n), .fall(fall), .busy(busy),
  .op_fail(op_fail), .op_valid(op_valid), .op_kind(op_kind),
  .op_addr(op_addr), .sect_prot(sect_prot)
);

// File: tb/flash_cmd_seq_tb_top.sv
module flash_cmd_seq_tb_top;
  localparam int CLK_P = 10;
  localparam int BUSYN = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we_n = 1'b1;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [15:0] sect_prot = '0;
  logic [5:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       busy, op_fail;

  int checks = 0;
  int bad = 0;

  always #(CLK_P/2) clk = ~clk;

  flash_cmd_seq #(.BUSY_CYC(BUSYN)) dut_i (
    .clk(clk), .rst_n(rst_n), .we_n(we_n), .addr(addr), .wdata(wdata),
    .sect_prot(sect_prot), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .op_fail(op_fail)
  );

  // Behavioural reference model
  logic [7:0] mmem [64];
  int  mst, mcnt;
  bit  mfail, mprev;

  task automatic m_wipe(input int s);
    for (int w = 0; w < 4; w++) mmem[s*4 + w] = 8'hFF;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mmem[i] = 8'hFF;
      mst = 0; mcnt = 0; mfail = 0; mprev = 1;
    end else begin
      bit acc;
      int a, d, s;
      acc = 0;
      a = int'(addr); d = int'(wdata); s = a / 4;
      if (mprev && !we_n && mcnt == 0) begin
        if (mst == 0)      mst = (a == 'h15 && d == 'hAA) ? 1 : 0;
        else if (mst == 1) mst = (a == 'h2A && d == 'h55) ? 2 : 0;
        else if (mst == 2) mst = (a == 'h15 && d == 'hA0) ? 3 :
                                 (a == 'h15 && d == 'h80) ? 4 : 0;
        else if (mst == 3) begin
          acc = 1; mst = 0;
          if (sect_prot[s]) mfail = 1;
          else begin mmem[a] = mmem[a] & wdata; mfail = 0; end
        end
        else if (mst == 4) mst = (a == 'h15 && d == 'hAA) ? 5 : 0;
        else if (mst == 5) mst = (a == 'h2A && d == 'h55) ? 6 : 0;
        else begin
          mst = 0;
          if (d == 'h30) begin
            acc = 1;
            if (sect_prot[s]) mfail = 1;
            else begin m_wipe(s); mfail = 0; end
          end else if (d == 'h20) begin
            acc = 1; mfail = 0;
            for (int k = (a/16)*4; k < (a/16)*4 + 4; k++)
              if (!sect_prot[k]) m_wipe(k);
          end
        end
      end
      if (acc) mcnt = BUSYN;
      else if (mcnt > 0) mcnt = mcnt - 1;
      mprev = we_n;
    end
    #(CLK_P/4);
    if (rst_n) begin
      checks += 3;
      if (rd_data !== mmem[rd_addr]) begin
        bad++; $display("FAIL R10 model rd_data act=%h exp=%h", rd_data, mmem[rd_addr]);
      end
      if (busy !== (mcnt != 0)) begin
        bad++; $display("FAIL R8 model busy act=%b exp=%b", busy, mcnt != 0);
      end
      if (op_fail !== mfail) begin
        bad++; $display("FAIL R6 model op_fail act=%b exp=%b", op_fail, mfail);
      end
    end
  end

  task automatic check_val(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      bad++; $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_rd(input string tag, input logic [5:0] a, input logic [7:0] exp);
    @(negedge clk); rd_addr = a; #1;
    check_val(tag, int'(rd_data), int'(exp));
  endtask

  task automatic strobe(input logic [5:0] a, input logic [7:0] d, input int hold);
    @(negedge clk); addr = a; wdata = d; we_n = 1'b0;
    repeat (hold) @(negedge clk);
    we_n = 1'b1;
  endtask

  task automatic prog(input logic [5:0] a, input logic [7:0] d);
    strobe(6'h15, 8'hAA, 1); strobe(6'h2A, 8'h55, 1);
    strobe(6'h15, 8'hA0, 1); strobe(a, d, 1);
  endtask

  task automatic erase(input logic [5:0] a, input logic [7:0] c);
    strobe(6'h15, 8'hAA, 1); strobe(6'h2A, 8'h55, 1); strobe(6'h15, 8'h80, 1);
    strobe(6'h15, 8'hAA, 1); strobe(6'h2A, 8'h55, 1); strobe(a, c, 1);
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check_rd("R1 word0", 6'h00, 8'hFF);
    check_rd("R1 word63", 6'h3F, 8'hFF);
    check_val("R1 busy", int'(busy), 0);
    check_val("R1 fail", int'(op_fail), 0);

    // R2 program, R8 busy length
    prog(6'h05, 8'h3C);
    check_val("R8 busy after accept", int'(busy), 1);
    n = 0;
    while (busy === 1'b1 && n < 100) begin n++; @(negedge clk); end
    check_val("R8 busy length", n, BUSYN);
    check_rd("R2 program", 6'h05, 8'h3C);

    // R3 AND-only programming
    prog(6'h05, 8'hF0); settle();
    check_rd("R3 and-merge", 6'h05, 8'h30);
    check_val("R3 fail clear", int'(op_fail), 0);

    // R6 protection
    prog(6'h09, 8'h12); settle();
    @(negedge clk); sect_prot = 16'h0004;
    prog(6'h09, 8'h00); settle();
    check_rd("R6 prog blocked", 6'h09, 8'h12);
    check_val("R6 prog fail", int'(op_fail), 1);
    erase(6'h0A, 8'h30); settle();
    check_rd("R6 erase blocked", 6'h09, 8'h12);
    check_val("R6 erase fail", int'(op_fail), 1);

    // R4 sector erase
    prog(6'h06, 8'h00); settle();
    erase(6'h05, 8'h30); settle();
    check_rd("R4 sector word5", 6'h05, 8'hFF);
    check_rd("R4 sector word6", 6'h06, 8'hFF);
    check_val("R4 fail clear", int'(op_fail), 0);

    // R5 plane erase skipping protected sector
    prog(6'h01, 8'h11); settle();
    prog(6'h0D, 8'h22); settle();
    prog(6'h15, 8'h44); settle();
    erase(6'h03, 8'h20); settle();
    check_rd("R5 plane sector0", 6'h01, 8'hFF);
    check_rd("R5 plane sector3", 6'h0D, 8'hFF);
    check_rd("R5 protected kept", 6'h09, 8'h12);
    check_rd("R5 other plane kept", 6'h15, 8'h44);
    check_val("R5 no fail", int'(op_fail), 0);

    // R7 mismatch returns to idle
    strobe(6'h15, 8'hAA, 1); strobe(6'h2A, 8'h55, 1);
    strobe(6'h14, 8'hA0, 1); strobe(6'h20, 8'h00, 1); settle();
    check_rd("R7 wrong address", 6'h20, 8'hFF);
    strobe(6'h15, 8'hAA, 1); strobe(6'h2A, 8'h56, 1);
    strobe(6'h15, 8'hA0, 1); strobe(6'h21, 8'h00, 1); settle();
    check_rd("R7 wrong data", 6'h21, 8'hFF);
    prog(6'h21, 8'h77); settle();
    check_rd("R7 recovery", 6'h21, 8'h77);

    // R8 cycles during busy dropped
    prog(6'h30, 8'h0F);
    prog(6'h31, 8'h00); settle();
    check_rd("R8 first kept", 6'h30, 8'h0F);
    check_rd("R8 second dropped", 6'h31, 8'hFF);

    // R9 long low strobe counts once
    strobe(6'h15, 8'hAA, 4); strobe(6'h2A, 8'h55, 1);
    strobe(6'h15, 8'hA0, 3); strobe(6'h38, 8'h5A, 1); settle();
    check_rd("R9 held strobe", 6'h38, 8'h5A);

    // R10 read same word across commit
    @(negedge clk); rd_addr = 6'h3A;
    strobe(6'h15, 8'hAA, 1); strobe(6'h2A, 8'h55, 1); strobe(6'h15, 8'hA0, 1);
    @(negedge clk); addr = 6'h3A; wdata = 8'h66; we_n = 1'b0; #1;
    check_val("R10 before commit", int'(rd_data), 'hFF);
    @(negedge clk); we_n = 1'b1; #1;
    check_val("R10 after commit", int'(rd_data), 'h66);
    settle();

    finish_run();
  end
endmodule